// File: doc/BRIEF.md
# Packet MAC Hardware Controller

This block connects a processor bus to the byte streams of a baseband PHY and moves packets both ways under control of software. Software sees a small register window: control and status words, the station's own address, a transmit length, two transmit write ports (header and payload) and one receive read port. A scheduler in the top level decodes every bus access and starts the transmit and receive engines from the register settings.

On transmit, software loads `HDR_LEN` header bytes and the payload bytes, writes the payload byte count, then sets the start bit. The block sends the header, then the payload, then a 32-bit CRC over both. The stream is valid/ready: a byte moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low the block holds `tx_data` and `tx_last`. On receive, the block stores each incoming byte as it arrives, computes the CRC and takes the destination address from the first two bytes. At the end of the packet it either keeps the stored bytes and raises `irq`, or moves the receive write pointer back to where the packet began and counts a drop. `rx_ready` is high at all times after reset: the receive side never applies back-pressure. A packet that does not fit in the free space is dropped.

The CRC uses polynomial 0x04C11DB7. It starts from all ones, shifts each byte in MSB first, and the result is inverted. It is carried on the wire least significant byte first.

Top module: `pkt_mac_ctrl`

## Requirements
- R1: The bus window decodes byte addresses as follows. 0x00 is control: bit1 receive enable, which reads back; bit0 start, which is write-only. 0x04 is status: bit0 transmit busy, bit1 receive ready, bit2 CRC error, bit3 receive data available, bits 23:16 length of the last accepted packet. 0x08 is the own address (bits 15:0). 0x0C is the payload length (bits 7:0). 0x10 is the header write port and 0x14 the payload write port (bits 7:0). 0x18 is the receive read port: a read pops one byte, or returns 0 when no byte is available. 0x1C is the drop counter. Unlisted addresses read 0.
- R2: A transmitted packet is the `HDR_LEN` header bytes in written order, then exactly the programmed number of payload bytes (0 is allowed), then 4 CRC bytes. `tx_last` is high only on the final CRC byte.
- R3: The transmitted CRC is computed over header and payload as defined above and sent least significant byte first.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged in the next cycle. No byte is lost or repeated.
- R5: Status busy is 1 from the cycle after a start write until the final CRC byte is accepted. A start write while busy is ignored and produces no second packet.
- R6: With receive enabled, a packet is accepted when all of the following hold: it has at least `HDR_LEN`+4 bytes, bytes 0 and 1 (low byte first) equal the own address, its trailing 4 bytes equal the CRC of the rest, and it fit in the receive FIFO. An accepted packet can be read back in full, CRC included, and status bits 23:16 give its length.
- R7: A packet that fails any condition of R6 while receive is enabled leaves no byte readable, does not raise `irq`, and increments the drop counter by one. Bytes already accepted stay intact.
- R8: Status bit2 is set when a packet of legal length fails the CRC check. It is cleared by writing 1 to bit2 of 0x04.
- R9: A packet whose first byte arrives while receive is disabled is consumed and discarded without changing the FIFO, the drop counter or `irq`.
- R10: `irq` equals status bit1. It is set when a packet is accepted and stays high until software writes 1 to bit1 of 0x04.
- R11: `rx_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (a read of 0x18 pops one byte) |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from the address |
| irq | output | 1 | Receive interrupt, level |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | PHY accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts receive bytes |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive packet |

## Verification
A transmit engine stuck in the wrong state, or a wrong byte counter, shows on the very next accepted transmit byte: the data or the `tx_last` flag differs from what the scoreboard expects, or a byte appears that nobody asked for. A receive pointer that was not rewound shows at the first later read of 0x18. The bench reads the stored packet right after each drop, so foreign bytes placed ahead of it are visible. Errors in the CRC window or the address capture show in the cycle after the last byte of the packet: `irq`, the drop counter and the CRC error bit must all agree with the bench's own CRC.

// File: rtl/pkt_mac_pkg.sv
package pkt_mac_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_OWN  = 5'h08;
  localparam logic [4:0] A_TLEN = 5'h0C;
  localparam logic [4:0] A_HDR  = 5'h10;
  localparam logic [4:0] A_DAT  = 5'h14;
  localparam logic [4:0] A_RXD  = 5'h18;
  localparam logic [4:0] A_DROP = 5'h1C;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PAY, TX_CRC} tx_state_e;

  // one byte into the CRC register, MSB first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      r = (r[31] ^ d[i]) ? ({r[30:0], 1'b0} ^ CRC_POLY) : {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/pkt_fifo.sv
// Byte FIFO with show-ahead read. Written data becomes readable only once it is
// committed; a rewind discards everything written since the last commit.
// DEPTH must be a power of two.
module pkt_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  input  logic         rewind,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, cptr, rptr;
  logic         push;

  assign full    = (wptr - rptr) == FULL_CNT;
  assign empty   = (cptr == rptr);
  assign rd_data = mem[rptr[AW-1:0]];
  assign push    = wr_en && !full && !rewind;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      cptr <= '0;
      rptr <= '0;
    end else begin
      if (rewind)    wptr <= cptr;
      else if (push) wptr <= wptr + 1'b1;
      if (commit)    cptr <= push ? wptr + 1'b1 : wptr;
      if (rd_en && !empty) rptr <= rptr + 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr) <= FULL_CNT);
  // R7
  commit_rewind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && rewind));
endmodule

// File: rtl/pkt_tx_eng.sv
module pkt_tx_eng
  import pkt_mac_pkg::*;
#(
  parameter int HDR_LEN = 4,
  parameter int LW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] pay_len,
  input  logic [7:0]    hdr_data,
  input  logic          hdr_empty,
  output logic          hdr_pop,
  input  logic [7:0]    dat_data,
  input  logic          dat_empty,
  output logic          dat_pop,
  output logic          busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  tx_state_e     state;
  logic [LW-1:0] cnt, len_q;
  logic [31:0]   crc, crc_out;
  logic          fire;

  assign crc_out = ~crc;
  assign busy    = (state != TX_IDLE);
  assign fire    = tx_valid && tx_ready;
  assign hdr_pop = fire && (state == TX_HDR);
  assign dat_pop = fire && (state == TX_PAY);

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    tx_last  = 1'b0;
    case (state)
      TX_HDR: begin tx_valid = !hdr_empty; tx_data = hdr_data; end
      TX_PAY: begin tx_valid = !dat_empty; tx_data = dat_data; end
      TX_CRC: begin
        tx_valid = 1'b1;
        tx_data  = crc_out[8*cnt[1:0] +: 8];
        tx_last  = (cnt[1:0] == 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      len_q <= '0;
      crc   <= '1;
    end else begin
      case (state)
        TX_IDLE: if (start) begin
          len_q <= pay_len;
          cnt   <= '0;
          crc   <= '1;
          state <= TX_HDR;
        end
        TX_HDR: if (fire) begin
          crc <= crc_byte(crc, tx_data);
          if (cnt == LW'(HDR_LEN - 1)) begin
            cnt   <= '0;
            state <= (len_q == '0) ? TX_CRC : TX_PAY;
          end else cnt <= cnt + 1'b1;
        end
        TX_PAY: if (fire) begin
          crc <= crc_byte(crc, tx_data);
          if (cnt == len_q - 1'b1) begin
            cnt   <= '0;
            state <= TX_CRC;
          end else cnt <= cnt + 1'b1;
        end
        TX_CRC: if (fire) begin
          if (tx_last) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_valid && tx_ready && tx_last));
endmodule

// File: rtl/pkt_rx_eng.sv
module pkt_rx_eng
  import pkt_mac_pkg::*;
#(
  parameter int HDR_LEN = 4,
  parameter int LW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [15:0]   own_addr,
  input  logic          rx_fire,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          fifo_full,
  output logic          fifo_wr,
  output logic          fifo_commit,
  output logic          fifo_rewind,
  output logic          pkt_ok,
  output logic          pkt_bad,
  output logic          crc_bad,
  output logic [LW-1:0] pkt_len
);
  logic [LW-1:0] cnt;
  logic          keep, ovf;
  logic [31:0]   win, crc, crc_fin, fcs;
  logic [15:0]   dest;
  logic          pkt_en, len_ok, crc_ok, addr_ok, end_pkt;

  assign pkt_en  = (cnt == '0) ? enable : keep;
  assign fifo_wr = rx_fire && pkt_en;
  assign crc_fin = crc_byte(crc, win[31:24]);
  assign fcs     = {rx_data, win[7:0], win[15:8], win[23:16]};
  assign len_ok  = (cnt >= LW'(HDR_LEN + 3)) && (cnt != '1);
  assign crc_ok  = (~crc_fin == fcs);
  assign addr_ok = (dest == own_addr);
  assign end_pkt = rx_fire && rx_last && pkt_en;
  assign pkt_len = cnt + 1'b1;

  assign pkt_ok      = end_pkt && len_ok && crc_ok && addr_ok && !ovf && !fifo_full;
  assign pkt_bad     = end_pkt && !pkt_ok;
  assign crc_bad     = end_pkt && len_ok && !crc_ok;
  assign fifo_commit = pkt_ok;
  assign fifo_rewind = pkt_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      keep <= 1'b0;
      ovf  <= 1'b0;
      win  <= '0;
      crc  <= '1;
      dest <= '0;
    end else if (rx_fire) begin
      win <= {win[23:0], rx_data};
      if (cnt == '0)       keep <= enable;
      if (cnt == LW'(0))   dest[7:0]  <= rx_data;
      if (cnt == LW'(1))   dest[15:8] <= rx_data;
      if (rx_last) begin
        cnt <= '0;
        ovf <= 1'b0;
        crc <= '1;
      end else begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (pkt_en && fifo_full) ovf <= 1'b1;
        if (cnt >= LW'(4)) crc <= crc_fin;
      end
    end
  end

  // R9
  rx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && cnt == '0 && !enable) |-> !fifo_wr);
endmodule

// File: rtl/pkt_mac_ctrl.sv
module pkt_mac_ctrl
  import pkt_mac_pkg::*;
#(
  parameter int HDR_LEN   = 4,
  parameter int TXH_DEPTH = 8,
  parameter int TXD_DEPTH = 64,
  parameter int RX_DEPTH  = 64,
  parameter int LW        = 8,
  parameter int DROP_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last
);
  logic              rx_en, rx_rdy, crc_err, ready_q;
  logic [15:0]       own_addr;
  logic [LW-1:0]     tx_len, rx_len, pkt_len;
  logic [DROP_W-1:0] drop_cnt;
  logic              busy, start, stat_wr;
  logic              hdr_pop, hdr_full, hdr_empty, dat_pop, dat_full, dat_empty;
  logic [7:0]        hdr_q, dat_q, rxf_q;
  logic              rxf_wr, rxf_commit, rxf_rewind, rxf_full, rxf_empty, rxf_pop;
  logic              pkt_ok, pkt_bad, crc_bad;

  // address decode
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign start   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0] && !busy;
  assign rxf_pop = bus_rd && (bus_addr == A_RXD);
  assign rx_ready = ready_q;
  assign irq      = rx_rdy;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {30'b0, rx_en, 1'b0};
      A_STAT:  bus_rdata = (32'(rx_len) << 16) | {28'b0, !rxf_empty, crc_err, rx_rdy, busy};
      A_OWN:   bus_rdata = {16'b0, own_addr};
      A_TLEN:  bus_rdata = 32'(tx_len);
      A_RXD:   bus_rdata = rxf_empty ? 32'b0 : {24'b0, rxf_q};
      A_DROP:  bus_rdata = 32'(drop_cnt);
      default: bus_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      own_addr <= '0;
      tx_len   <= '0;
      rx_rdy   <= 1'b0;
      crc_err  <= 1'b0;
      rx_len   <= '0;
      drop_cnt <= '0;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (bus_wr && bus_addr == A_CTRL) rx_en    <= bus_wdata[1];
      if (bus_wr && bus_addr == A_OWN)  own_addr <= bus_wdata[15:0];
      if (bus_wr && bus_addr == A_TLEN) tx_len   <= bus_wdata[LW-1:0];
      if (pkt_ok) begin
        rx_rdy <= 1'b1;
        rx_len <= pkt_len;
      end else if (stat_wr && bus_wdata[1]) rx_rdy <= 1'b0;
      if (crc_bad) crc_err <= 1'b1;
      else if (stat_wr && bus_wdata[2]) crc_err <= 1'b0;
      if (pkt_bad) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  pkt_fifo #(.DEPTH(TXH_DEPTH), .W(8)) u_hdr_fifo (
    .clk, .rst_n, .wr_en(bus_wr && bus_addr == A_HDR), .wr_data(bus_wdata[7:0]),
    .commit(1'b1), .rewind(1'b0), .rd_en(hdr_pop), .rd_data(hdr_q),
    .full(hdr_full), .empty(hdr_empty));

  pkt_fifo #(.DEPTH(TXD_DEPTH), .W(8)) u_dat_fifo (
    .clk, .rst_n, .wr_en(bus_wr && bus_addr == A_DAT), .wr_data(bus_wdata[7:0]),
    .commit(1'b1), .rewind(1'b0), .rd_en(dat_pop), .rd_data(dat_q),
    .full(dat_full), .empty(dat_empty));

  pkt_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rx_fifo (
    .clk, .rst_n, .wr_en(rxf_wr), .wr_data(rx_data),
    .commit(rxf_commit), .rewind(rxf_rewind), .rd_en(rxf_pop), .rd_data(rxf_q),
    .full(rxf_full), .empty(rxf_empty));

  pkt_tx_eng #(.HDR_LEN(HDR_LEN), .LW(LW)) u_tx (
    .clk, .rst_n, .start, .pay_len(tx_len),
    .hdr_data(hdr_q), .hdr_empty, .hdr_pop,
    .dat_data(dat_q), .dat_empty, .dat_pop,
    .busy, .tx_valid, .tx_ready, .tx_data, .tx_last);

  pkt_rx_eng #(.HDR_LEN(HDR_LEN), .LW(LW)) u_rx (
    .clk, .rst_n, .enable(rx_en), .own_addr,
    .rx_fire(rx_valid && rx_ready), .rx_data, .rx_last,
    .fifo_full(rxf_full), .fifo_wr(rxf_wr),
    .fifo_commit(rxf_commit), .fifo_rewind(rxf_rewind),
    .pkt_ok, .pkt_bad, .crc_bad, .pkt_len);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(stat_wr && bus_wdata[1])) |=> irq);
  // R7
  drop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_bad && !irq) |=> !irq);
endmodule

// File: tb/pkt_mac_ctrl_bench.sv
module pkt_mac_ctrl_bench;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, tx_valid, tx_last, rx_ready;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [8:0] exp_q[$];
  logic [31:0] rv;

  always #2 clk = ~clk;

  pkt_mac_ctrl u_pkt_mac_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[k]) begin
      for (int i = 7; i >= 0; i--) begin
        if (c[31] ^ b[k][i]) c = {c[30:0], 1'b0} ^ POLY;
        else c = {c[30:0], 1'b0};
      end
    end
    return ~c;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: tx_ready pattern set at each falling edge, handshake scored there
  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 3) != 0;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check("R2 unexpected tx byte", {23'b0, tx_last, tx_data}, 32'h1FF);
      else check("R2/R3/R4 tx byte", {23'b0, tx_last, tx_data}, {23'b0, exp_q.pop_front()});
    end
  end

  task automatic tx_send(input logic [7:0] hdr[$], input logic [7:0] pay[$]);
    logic [7:0] all[$];
    logic [31:0] c;
    foreach (hdr[i]) wr(5'h10, {24'b0, hdr[i]});
    foreach (pay[i]) wr(5'h14, {24'b0, pay[i]});
    wr(5'h0C, pay.size());
    all = {hdr, pay};
    c = ref_crc(all);
    foreach (all[i]) exp_q.push_back({1'b0, all[i]});
    for (int i = 0; i < 4; i++) exp_q.push_back({i == 3, c[8*i +: 8]});
    wr(5'h00, 32'h1);
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R2 all tx bytes delivered", exp_q.size(), 0);
  endtask

  task automatic make_pkt(output logic [7:0] p[$], input logic [15:0] dest,
                          input int nbody, input bit bad);
    logic [31:0] c;
    p = {};
    p.push_back(dest[7:0]);
    p.push_back(dest[15:8]);
    for (int i = 0; i < nbody; i++) p.push_back(8'(i * 7 + 3));
    c = ref_crc(p);
    if (bad) c = c ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) p.push_back(c[8*i +: 8]);
  endtask

  task automatic rx_send(input logic [7:0] p[$]);
    foreach (p[i]) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = p[i]; rx_last = (i == p.size() - 1);
    end
    @(negedge clk);
    check("R11 rx_ready high", rx_ready, 1'b1);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic rx_readback(input string req, input logic [7:0] p[$]);
    logic [31:0] d;
    foreach (p[i]) begin
      rd(5'h18, d);
      check(req, d, {24'b0, p[i]});
    end
    rd(5'h04, d);
    check({req, " fifo drained"}, d[3], 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    finish_test();
  end

  initial begin
    logic [7:0] p[$], good[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(5'h04, rv); check("R1 reset status", rv, 0);
    check("R10 reset irq", irq, 1'b0);
    check("R2 reset tx_valid", tx_valid, 1'b0);
    rd(5'h1C, rv); check("R1 reset drop count", rv, 0);
    check("R11 rx_ready after reset", rx_ready, 1'b1);

    // register window
    wr(5'h08, 32'h0000_1234); rd(5'h08, rv); check("R1 own address", rv, 32'h1234);
    wr(5'h0C, 32'h0000_0011); rd(5'h0C, rv); check("R1 tx length", rv, 32'h11);
    rd(5'h14, rv); check("R1 write-only port reads 0", rv, 0);

    // transmit, busy, start ignored while busy
    tx_send('{8'hA1, 8'hB2, 8'hC3, 8'hD4}, '{8'h10, 8'h20, 8'h30, 8'h40, 8'h55});
    rd(5'h04, rv); check("R5 busy after start", rv[0], 1'b1);
    wr(5'h00, 32'h1);
    wait_tx();
    rd(5'h04, rv); check("R5 idle after packet", rv[0], 1'b0);

    // zero payload
    tx_send('{8'h01, 8'h02, 8'h03, 8'h04}, '{});
    wait_tx();
    // longer payload with back-pressure
    begin
      logic [7:0] pl[$];
      for (int i = 0; i < 40; i++) pl.push_back(8'(i * 13));
      tx_send('{8'hFF, 8'h00, 8'h5A, 8'hA5}, pl);
      wait_tx();
    end

    // receive: accepted packet
    wr(5'h00, 32'h2);
    rd(5'h00, rv); check("R1 rx enable readback", rv, 32'h2);
    make_pkt(good, 16'h1234, 10, 1'b0);
    rx_send(good);
    check("R10 irq on accept", irq, 1'b1);
    rd(5'h04, rv);
    check("R6 rx ready bit", rv[1], 1'b1);
    check("R6 rx length", rv[23:16], 8'(good.size()));
    rx_readback("R6 stored byte", good);
    check("R10 irq held until cleared", irq, 1'b1);
    wr(5'h04, 32'h2);
    check("R10 irq cleared by W1C", irq, 1'b0);

    // foreign address
    make_pkt(p, 16'h4321, 10, 1'b0);
    rx_send(p);
    check("R7 foreign no irq", irq, 1'b0);
    rd(5'h1C, rv); check("R7 drop count foreign", rv, 1);
    rd(5'h04, rv); check("R7 foreign nothing stored", rv[3], 1'b0);

    // bad CRC
    make_pkt(p, 16'h1234, 6, 1'b1);
    rx_send(p);
    rd(5'h04, rv);
    check("R8 crc error bit", rv[2], 1'b1);
    check("R7 bad crc nothing stored", rv[3], 1'b0);
    rd(5'h1C, rv); check("R7 drop count crc", rv, 2);
    wr(5'h04, 32'h4);
    rd(5'h04, rv); check("R8 crc error cleared", rv[2], 1'b0);

    // too short (7 bytes)
    make_pkt(p, 16'h1234, 1, 1'b0);
    rx_send(p);
    rd(5'h1C, rv); check("R7 drop count short", rv, 3);
    rd(5'h04, rv); check("R8 short packet is not a crc error", rv[2], 1'b0);

    // good packet after drops: rewind left nothing behind
    make_pkt(good, 16'h1234, 4, 1'b0);
    rx_send(good);
    check("R10 irq second accept", irq, 1'b1);
    rx_readback("R7 rewind clean byte", good);
    wr(5'h04, 32'h2);

    // overflow: 70 bytes into a 64-byte FIFO
    make_pkt(p, 16'h1234, 64, 1'b0);
    rx_send(p);
    check("R7 overflow no irq", irq, 1'b0);
    rd(5'h1C, rv); check("R7 drop count overflow", rv, 4);
    rd(5'h04, rv); check("R7 overflow nothing stored", rv[3], 1'b0);

    // receive disabled
    wr(5'h00, 32'h0);
    make_pkt(p, 16'h1234, 8, 1'b0);
    rx_send(p);
    check("R9 disabled no irq", irq, 1'b0);
    rd(5'h1C, rv); check("R9 disabled drop count unchanged", rv, 4);
    rd(5'h04, rv); check("R9 disabled nothing stored", rv[3], 1'b0);
    rd(5'h18, rv); check("R1 empty read returns 0", rv, 0);

    repeat (5) @(negedge clk);
    finish_test();
  end
endmodule